// File: doc/BRIEF.md
# Paired Byte/Word Register File

This block holds eight 8-bit general registers that can also be handled as four 16-bit pairs. Both views share a single storage array, so a byte write is seen at once through the pair that contains it, and a pair write updates both of its bytes. A separate 16-bit stack pointer sits beside the array. Two byte read ports and one pair read port are combinational. One byte-write operation and one word operation can be issued in each clock cycle.

Byte register 0 is the accumulator, and the byte-write operations follow that convention. A memory byte load always lands in register 0. A copy moves a value into register 0 or out of it, and no other register-to-register path exists. The word side loads a pair, increments it or decrements it. The word side also copies a pair into the stack pointer or the stack pointer into a pair. An increment or a decrement reports a zero-flag update for the flags register, which lives outside this block. The carry, overflow and negative flags are not touched. A dedicated adder forms the base-plus-offset memory address from a pair and an unsigned byte offset. The same adder serves the zero-offset form.

Top module: `pair_regfile`

## Requirements
- R1: After reset, every byte register and the stack pointer read as 0.
- R2: The byte read ports return register `rd_a_sel` / `rd_b_sel`, and the word read port returns pair N as {byte 2N+1, byte 2N}. All reads are combinational and show a write from the following cycle on.
- R3: With `bop`=1 (immediate), byte register `bw_sel` takes `bw_data` at the clock edge.
- R4: With `bop`=2 (memory load), register 0 takes `bw_data`, `bw_sel` is ignored, and no other register changes.
- R5: With `bop`=3, register 0 takes the old value of register `bw_sel`. With `bop`=4, register `bw_sel` takes the old value of register 0, and when `bw_sel`=0 nothing changes. `bop` codes 0, 5, 6 and 7 change nothing.
- R6: With `wop`=1 (load), pair `ww_sel` takes `ww_data`.
- R7: `wop`=2 increments pair `ww_sel` and `wop`=3 decrements it, both modulo 65536 with the carry passing between the bytes. In that cycle `z_upd` is 1 and `z_next` is 1 exactly when the 16-bit result is 0.
- R8: For every `wop` other than 2 and 3, `z_upd` is 0, so the flags stay unchanged.
- R9: `wop`=5 copies pair `ww_sel` into the stack pointer and leaves the registers alone. `wop`=4 copies the stack pointer into pair `ww_sel`. `sp_q` shows the stack pointer.
- R10: When `wop` is 1, 2, 3 or 4, the byte operation in the same cycle is dropped completely, even when it targets another pair.
- R11: `ea_addr` equals pair `ea_sel` plus `ea_off`, zero-extended, modulo 65536. When `ea_use_off`=0 the offset is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_sel | input | 3 | Byte read port A select |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_sel | input | 3 | Byte read port B select |
| rd_b_data | output | 8 | Byte read port B data |
| rd_w_sel | input | 2 | Pair read port select |
| rd_w_data | output | 16 | Pair read port data |
| bop | input | 3 | Byte operation code |
| bw_sel | input | 3 | Byte operation register select |
| bw_data | input | 8 | Byte operation data (immediate or memory) |
| wop | input | 3 | Word operation code |
| ww_sel | input | 2 | Word operation pair select |
| ww_data | input | 16 | Word load data |
| sp_q | output | 16 | Stack pointer |
| z_upd | output | 1 | Zero flag write strobe |
| z_next | output | 1 | Zero flag value for the strobe |
| ea_sel | input | 2 | Address base pair select |
| ea_off | input | 8 | Unsigned address offset |
| ea_use_off | input | 1 | 1 adds the offset, 0 selects the zero-offset form |
| ea_addr | output | 16 | Effective address |

## Verification
The bench drives several cases where a wrong carry shows up in the result. An increment of 0x00FF must give 0x0100, and a design that keeps the bytes apart would return 0x0000. An increment of 0xFFFF and a decrement of 0x0001 must both give zero, and each must raise `z_next`. A base of 0xFFF0 with an offset of 0xF0 must wrap to 0x00E0. An offset of 0x80 must not be sign-extended. The bench also tests the cases that a loose decoder would get wrong: a copy out of the accumulator to register 0, a memory load with a non-zero select, and a byte write issued alongside a word write to another pair. Each of these must leave all of the untargeted registers unchanged.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic [2:0] {
    BOP_NONE     = 3'd0,
    BOP_IMM      = 3'd1,
    BOP_MEM      = 3'd2,
    BOP_TO_ACC   = 3'd3,
    BOP_FROM_ACC = 3'd4
  } byte_op_e;

  typedef enum logic [2:0] {
    WOP_NONE    = 3'd0,
    WOP_LOAD    = 3'd1,
    WOP_INC     = 3'd2,
    WOP_DEC     = 3'd3,
    WOP_FROM_SP = 3'd4,
    WOP_TO_SP   = 3'd5
  } word_op_e;

endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 8,
  localparam int BSEL_W   = $clog2(NUM_BYTES),
  localparam int WSEL_W   = BSEL_W - 1,
  localparam int WORD_W   = 2 * BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_we,
  input  logic [BSEL_W-1:0]           byte_idx,
  input  logic [BYTE_W-1:0]           byte_val,
  input  logic                        word_we,
  input  logic [WSEL_W-1:0]           word_idx,
  input  logic [WORD_W-1:0]           word_val,
  output logic [NUM_BYTES*BYTE_W-1:0] bytes_flat
);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_cell
    logic [BYTE_W-1:0] cell_q;
    logic              hit_word;
    logic              hit_byte;

    assign hit_word = word_we && (word_idx == WSEL_W'(g / 2));
    assign hit_byte = byte_we && (byte_idx == BSEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (hit_word) begin
        cell_q <= (g % 2 == 1) ? word_val[WORD_W-1:BYTE_W] : word_val[BYTE_W-1:0];
      end else if (hit_byte) begin
        cell_q <= byte_val;
      end
    end

    assign bytes_flat[g*BYTE_W +: BYTE_W] = cell_q;
  end

endmodule

// File: rtl/rf_idu.sv
module rf_idu #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic              down,
  output logic [WORD_W-1:0] word_out,
  output logic              is_zero
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  function automatic logic [WORD_W-1:0] step_word(input logic [WORD_W-1:0] v,
                                                  input logic              dn);
    return dn ? (v - ONE) : (v + ONE);
  endfunction

  assign word_out = step_word(word_in, down);
  assign is_zero  = (word_out == '0);

endmodule

// File: rtl/rf_agu.sv
module rf_agu #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [WORD_W-1:0] base,
  input  logic [BYTE_W-1:0] off,
  input  logic              use_off,
  output logic [WORD_W-1:0] addr
);

  function automatic logic [WORD_W-1:0] form_addr(input logic [WORD_W-1:0] b,
                                                  input logic [BYTE_W-1:0] o,
                                                  input logic              u);
    logic [WORD_W-1:0] ext;
    ext = u ? {{(WORD_W-BYTE_W){1'b0}}, o} : '0;
    return b + ext;
  endfunction

  assign addr = form_addr(base, off, use_off);

endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import regfile_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                NUM_BYTES = 8,
  parameter logic [2*BYTE_W-1:0] SP_RESET = '0,
  localparam int BSEL_W = $clog2(NUM_BYTES),
  localparam int WSEL_W = BSEL_W - 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BSEL_W-1:0] rd_a_sel,
  output logic [BYTE_W-1:0] rd_a_data,
  input  logic [BSEL_W-1:0] rd_b_sel,
  output logic [BYTE_W-1:0] rd_b_data,
  input  logic [WSEL_W-1:0] rd_w_sel,
  output logic [WORD_W-1:0] rd_w_data,
  input  logic [2:0]        bop,
  input  logic [BSEL_W-1:0] bw_sel,
  input  logic [BYTE_W-1:0] bw_data,
  input  logic [2:0]        wop,
  input  logic [WSEL_W-1:0] ww_sel,
  input  logic [WORD_W-1:0] ww_data,
  output logic [WORD_W-1:0] sp_q,
  output logic              z_upd,
  output logic              z_next,
  input  logic [WSEL_W-1:0] ea_sel,
  input  logic [BYTE_W-1:0] ea_off,
  input  logic              ea_use_off,
  output logic [WORD_W-1:0] ea_addr
);

  logic [NUM_BYTES*BYTE_W-1:0] bytes_flat;
  logic [BYTE_W-1:0]           rv [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_unpack
    assign rv[g] = bytes_flat[g*BYTE_W +: BYTE_W];
  end

  function automatic logic [WORD_W-1:0] pair_of(input logic [WSEL_W-1:0] p);
    return {rv[{p, 1'b1}], rv[{p, 1'b0}]};
  endfunction

  // read ports
  assign rd_a_data = rv[rd_a_sel];
  assign rd_b_data = rv[rd_b_sel];
  assign rd_w_data = pair_of(rd_w_sel);

  // word side decode
  logic              word_we;
  logic [WORD_W-1:0] word_val;
  logic [WORD_W-1:0] ww_cur;
  logic [WORD_W-1:0] idu_out;
  logic              idu_zero;
  logic              idu_active;

  assign ww_cur     = pair_of(ww_sel);
  assign idu_active = (wop == WOP_INC) || (wop == WOP_DEC);

  rf_idu #(.WORD_W(WORD_W)) u_idu (
    .word_in  (ww_cur),
    .down     (wop == WOP_DEC),
    .word_out (idu_out),
    .is_zero  (idu_zero)
  );

  always_comb begin
    word_we  = 1'b0;
    word_val = ww_data;
    case (wop)
      WOP_LOAD:    word_we = 1'b1;
      WOP_INC,
      WOP_DEC:     begin word_we = 1'b1; word_val = idu_out; end
      WOP_FROM_SP: begin word_we = 1'b1; word_val = sp_q;    end
      default:     word_we = 1'b0;
    endcase
  end

  assign z_upd  = idu_active;
  assign z_next = idu_active && idu_zero;

  // byte side decode
  logic              byte_we;
  logic [BSEL_W-1:0] byte_idx;
  logic [BYTE_W-1:0] byte_val;

  always_comb begin
    byte_we  = 1'b0;
    byte_idx = bw_sel;
    byte_val = bw_data;
    case (bop)
      BOP_IMM:      byte_we = 1'b1;
      BOP_MEM:      begin byte_we = 1'b1; byte_idx = '0; end
      BOP_TO_ACC:   begin byte_we = 1'b1; byte_idx = '0; byte_val = rv[bw_sel]; end
      BOP_FROM_ACC: begin byte_we = (bw_sel != '0); byte_val = rv[0]; end
      default:      byte_we = 1'b0;
    endcase
    if (word_we) byte_we = 1'b0;
  end

  rf_storage #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_we    (byte_we),
    .byte_idx   (byte_idx),
    .byte_val   (byte_val),
    .word_we    (word_we),
    .word_idx   (ww_sel),
    .word_val   (word_val),
    .bytes_flat (bytes_flat)
  );

  // stack pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= SP_RESET;
    end else if (wop == WOP_TO_SP) begin
      sp_q <= ww_cur;
    end
  end

  // address generation
  rf_agu #(.BYTE_W(BYTE_W)) u_agu (
    .base    (pair_of(ea_sel)),
    .off     (ea_off),
    .use_off (ea_use_off),
    .addr    (ea_addr)
  );

endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk
  import regfile_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 8,
  localparam int BSEL_W = $clog2(NUM_BYTES),
  localparam int WSEL_W = BSEL_W - 1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2:0]                  bop,
  input logic [BSEL_W-1:0]           bw_sel,
  input logic [BYTE_W-1:0]           bw_data,
  input logic [2:0]                  wop,
  input logic [WSEL_W-1:0]           ww_sel,
  input logic [NUM_BYTES*BYTE_W-1:0] bytes_flat,
  input logic                        word_we,
  input logic [WORD_W-1:0]           word_val,
  input logic [WORD_W-1:0]           sp_q,
  input logic                        z_upd,
  input logic                        z_next,
  input logic [WSEL_W-1:0]           ea_sel,
  input logic [BYTE_W-1:0]           ea_off,
  input logic                        ea_use_off,
  input logic [WORD_W-1:0]           ea_addr
);

  function automatic logic [BYTE_W-1:0] byte_in(input logic [NUM_BYTES*BYTE_W-1:0] f,
                                                input logic [BSEL_W-1:0]           i);
    logic [BYTE_W-1:0] res;
    res = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (BSEL_W'(k) == i) res = f[k*BYTE_W +: BYTE_W];
    end
    return res;
  endfunction

  function automatic logic [WORD_W-1:0] pair_in(input logic [NUM_BYTES*BYTE_W-1:0] f,
                                                input logic [WSEL_W-1:0]           p);
    return {byte_in(f, {p, 1'b1}), byte_in(f, {p, 1'b0})};
  endfunction

  // R6
  word_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |=> pair_in(bytes_flat, $past(ww_sel)) == $past(word_val));

  // R10
  byte_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && bop == BOP_IMM && bw_sel[BSEL_W-1:1] != ww_sel)
    |=> byte_in(bytes_flat, $past(bw_sel)) == byte_in($past(bytes_flat), $past(bw_sel)));

  // R4
  mem_to_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && bop == BOP_MEM) |=> byte_in(bytes_flat, '0) == $past(bw_data));

  // R5
  self_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && bop == BOP_FROM_ACC && bw_sel == '0) |=> bytes_flat == $past(bytes_flat));

  // R9
  sp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wop == WOP_TO_SP) |=> sp_q == pair_in($past(bytes_flat), $past(ww_sel)));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (z_upd && z_next) |=> pair_in(bytes_flat, $past(ww_sel)) == '0);

  // R8
  z_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wop != WOP_INC && wop != WOP_DEC) |-> !z_upd);

  // R11
  ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_addr == WORD_W'(pair_in(bytes_flat, ea_sel)
                       + (ea_use_off ? {{(WORD_W-BYTE_W){1'b0}}, ea_off} : '0)));

endmodule

bind pair_regfile pair_regfile_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (.*);

// File: tb/tb_pair_regfile.sv
`timescale 1ns/1ps
module tb_pair_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_a_sel = '0, rd_b_sel = '0, bop = '0, bw_sel = '0, wop = '0;
  logic [1:0]  rd_w_sel = '0, ww_sel = '0, ea_sel = '0;
  logic [7:0]  rd_a_data, rd_b_data, bw_data = '0, ea_off = '0;
  logic [15:0] rd_w_data, ww_data = '0, sp_q, ea_addr;
  logic        z_upd, z_next, ea_use_off = 1'b0;

  always #10 clk = ~clk;

  pair_regfile dut (.*);

  int ref_r [8];
  int ref_sp;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_pair(input int p);
    return ref_r[2*p+1] * 256 + ref_r[2*p];
  endfunction

  // Check every stored value through the read ports, no operation pending
  task automatic sweep(input string tag);
    bop = 3'd0; wop = 3'd0;
    for (int i = 0; i < 8; i++) begin
      rd_a_sel = 3'(i); rd_b_sel = 3'(7 - i); #1;
      chk(tag, $sformatf("r%0d", i), int'(rd_a_data), ref_r[i]);
      chk(tag, $sformatf("r%0d(b)", 7 - i), int'(rd_b_data), ref_r[7 - i]);
    end
    for (int p = 0; p < 4; p++) begin
      rd_w_sel = 2'(p); #1;
      chk(tag, $sformatf("w%0d", p), int'(rd_w_data), ref_pair(p));
    end
    chk(tag, "sp", int'(sp_q), ref_sp);
  endtask

  task automatic step(input string tag, input int b_op, input int b_sel, input int b_dat,
                      input int w_op, input int w_sel, input int w_dat,
                      input int e_sel, input int e_off, input int e_use);
    int nr [8];
    int nsp, cur, res, exp_upd, exp_z;
    @(negedge clk);
    bop = 3'(b_op); bw_sel = 3'(b_sel); bw_data = 8'(b_dat);
    wop = 3'(w_op); ww_sel = 2'(w_sel); ww_data = 16'(w_dat);
    ea_sel = 2'(e_sel); ea_off = 8'(e_off); ea_use_off = 1'(e_use);
    rd_a_sel = 3'(b_sel); rd_b_sel = 3'((b_sel + 1) % 8); rd_w_sel = 2'(w_sel);
    #2;
    // combinational outputs against model
    cur = ref_pair(w_sel);
    res = cur;
    if (w_op == 2) res = (cur + 1) % 65536;
    if (w_op == 3) res = (cur + 65535) % 65536;
    exp_upd = (w_op == 2 || w_op == 3) ? 1 : 0;
    exp_z   = (exp_upd == 1 && res == 0) ? 1 : 0;
    chk("R2", "rd_a", int'(rd_a_data), ref_r[b_sel]);
    chk("R2", "rd_b", int'(rd_b_data), ref_r[(b_sel + 1) % 8]);
    chk("R2", "rd_w", int'(rd_w_data), cur);
    chk(exp_upd ? "R7" : "R8", "z_upd", int'(z_upd), exp_upd);
    if (exp_upd == 1) chk("R7", "z_next", int'(z_next), exp_z);
    chk("R11", "ea_addr", int'(ea_addr), (ref_pair(e_sel) + (e_use ? e_off : 0)) % 65536);
    // model next state
    for (int i = 0; i < 8; i++) nr[i] = ref_r[i];
    nsp = ref_sp;
    if (w_op >= 1 && w_op <= 4) begin
      if (w_op == 1) res = w_dat;
      if (w_op == 4) res = ref_sp;
      nr[2*w_sel]   = res % 256;
      nr[2*w_sel+1] = res / 256;
    end else begin
      case (b_op)
        1: nr[b_sel] = b_dat;
        2: nr[0] = b_dat;
        3: nr[0] = ref_r[b_sel];
        4: if (b_sel != 0) nr[b_sel] = ref_r[0];
        default: ;
      endcase
    end
    if (w_op == 5) nsp = cur;
    @(posedge clk);
    for (int i = 0; i < 8; i++) ref_r[i] = nr[i];
    ref_sp = nsp;
    #2;
    sweep(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ref_r[i] = 0;
    ref_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2; sweep("R1");

    // R3 immediate writes to every register
    for (int i = 0; i < 8; i++) step("R3", 1, i, 8'h11 * (i + 1), 0, 0, 0, 0, 0, 0);
    // R4 memory load ignores the select
    step("R4", 2, 5, 8'hA5, 0, 0, 0, 1, 0, 0);
    // R5 copies through the accumulator
    step("R5", 3, 3, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 4, 6, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 4, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 7, 2, 8'h5A, 0, 0, 0, 0, 0, 0);
    // R6 word loads
    step("R6", 0, 0, 0, 1, 2, 16'hFFFF, 2, 0, 1);
    step("R6", 0, 0, 0, 1, 0, 16'h00FF, 0, 0, 0);
    // R7 increment / decrement with wrap and carry between bytes
    step("R7", 0, 0, 0, 2, 2, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 3, 2, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 2, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 3, 16'h0001, 0, 0, 0);
    step("R7", 0, 0, 0, 3, 3, 0, 3, 0, 0);
    // R9 stack pointer copies
    step("R9", 0, 0, 0, 5, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 16'h1234, 0, 0, 0);
    step("R9", 0, 0, 0, 4, 3, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R10 word write blocks byte write
    step("R10", 1, 2, 8'h77, 1, 1, 16'hBEEF, 0, 0, 0);
    step("R10", 2, 0, 8'h99, 2, 0, 0, 0, 0, 0);
    step("R10", 4, 7, 0, 4, 2, 0, 0, 0, 0);
    // R11 address forming
    step("R11", 0, 0, 0, 1, 2, 16'hFFF0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 2, 8'hF0, 1);
    step("R11", 0, 0, 0, 0, 0, 0, 2, 8'hF0, 0);
    step("R11", 0, 0, 0, 1, 1, 16'h1000, 1, 8'h80, 1);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 8'h80, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule